// File: doc/BRIEF.md
# I2C Host Interrupt Status and Vector Unit

This block gathers the interrupt sources of an I2C host controller into one status register, masks them with an enable register and drives a single level-sensitive interrupt line. The rest of the controller (line sequencer, data buffer) reports its events as one-cycle pulses on `evt_i`. Software sees the unit through a 16-bit register port with a byte address, a write strobe and a read strobe. Read data is combinational from the current state, and any side effect of a read takes place at the clock edge that ends the read.

One parameter, `REV_CODE`, selects between two register generations. Code 0x11 is the older generation. There the status register is read-only, five sources can be enabled, and software acknowledges an interrupt by reading a vector register. That read returns and retires the lowest pending enabled source. Any code of 0x34 or above selects the newer generation. It has no vector register, six sources can be enabled, status bits are cleared by writing ones, and a test register bit can force every source pending.

Register offsets (byte address): 0x00 revision, 0x04 enable, 0x08 status, 0x0C vector, 0x3C system test. Every other offset reads as zero and ignores writes.

Top module: `i2c_irq_unit`

## Requirements
- R1: `irq_o` is high exactly when status AND enable is non-zero, and it follows every state change in the cycle after the edge that caused it.
- R2: On code 0x11, a read of offset 0x0C returns the 1-based index of the lowest set bit of status AND enable, and it clears only that status bit.
- R3: On code 0x11, a vector read with nothing pending and enabled returns 0 and leaves the status unchanged.
- R4: On code 0x34, a write to offset 0x08 clears each status bit 5:0 whose written bit is 1. A read of 0x0C returns 0 and clears nothing.
- R5: On code 0x11, a write to offset 0x08 leaves the status unchanged.
- R6: The enable register at 0x04 keeps written bits 4:0 on code 0x11 and bits 5:0 on code 0x34. All other bits read as 0.
- R7: A status read returns the stored bits 5:0, with bit 12 equal to the live `bus_busy_i` and all other bits 0.
- R8: Writes to offset 0x3C store the value ANDed with 0xF80F, and reads return it. On code 0x34, a write with bit 11 set sets status bits 5:0. On code 0x11, bit 11 has no effect on status.
- R9: Offset 0x00 reads the revision code and ignores writes.
- R10: An event pulse in the same cycle as a clearing write or vector read leaves its status bit set.
- R11: After reset the status, enable and test registers read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; side effects apply at the next edge |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| evt_i | input | 6 | One-cycle event pulses that set status bits |
| bus_busy_i | input | 1 | Live bus-busy flag shown in status bit 12 |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a collision: an event pulse lands in the same cycle that software retires that same bit, whether by a write-one-to-clear or by a vector read. The stimulus drives the event and the register access in the same cycle. It then reads the status back and watches the interrupt line to confirm the bit survived. A second hard case is the vector priority order when several enabled sources are pending together. A mixed event pattern that includes a source the older generation cannot enable is raised first. Repeated vector reads must then walk up the pending bits and finish by returning zero.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 16;

  localparam logic [AW-1:0] OFS_REV  = 6'h00;
  localparam logic [AW-1:0] OFS_IE   = 6'h04;
  localparam logic [AW-1:0] OFS_STAT = 6'h08;
  localparam logic [AW-1:0] OFS_VEC  = 6'h0C;
  localparam logic [AW-1:0] OFS_TEST = 6'h3C;

  localparam logic [7:0]    REV_OLD     = 8'h11;
  localparam logic [7:0]    REV_NEW_MIN = 8'h34;
  localparam logic [DW-1:0] TEST_KEEP   = 16'hF80F;
  localparam int unsigned   TEST_FORCE_BIT = 11;
  localparam int unsigned   BUSY_BIT       = 12;
endpackage

// File: rtl/i2c_irq_rstsync.sv
module i2c_irq_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_irq_lsb_enc.sv
module i2c_irq_lsb_enc #(
  parameter int unsigned N  = 6,
  parameter int unsigned VW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  sel_o
);
  always_comb begin
    vec_o = '0;
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vec_o = VW'(i + 1);
        sel_o = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         fill_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  always_comb begin
    stat_en = (|set_i) | (|clr_i) | fill_i;
    stat_d  = stat_q & ~clr_i;
    if (fill_i) stat_d = '1;
    stat_d  = stat_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter logic [7:0]  REV_CODE = 8'h34,
  parameter int unsigned SRC_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SRC_W-1:0] evt_i,
  input  logic             bus_busy_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam bit          IS_NEW = (REV_CODE >= REV_NEW_MIN);
  localparam int unsigned VW     = $clog2(SRC_W + 1);
  localparam logic [SRC_W-1:0] IE_KEEP = IS_NEW ? {SRC_W{1'b1}} : {1'b0, {(SRC_W-1){1'b1}}};

  logic             rst_sync_n;
  logic [SRC_W-1:0] stat_q, ie_q, ie_d, pend, vec_sel, clr;
  logic [DW-1:0]    test_q, test_d;
  logic [VW-1:0]    vec;
  logic             ie_en, test_en, fill, hit_ie, hit_stat, hit_vec, hit_test;

  i2c_irq_rstsync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  assign pend = stat_q & ie_q;

  i2c_irq_lsb_enc #(.N(SRC_W), .VW(VW)) u_enc (
    .pend_i(pend), .vec_o(vec), .sel_o(vec_sel)
  );

  always_comb begin
    hit_ie   = (addr_i == OFS_IE);
    hit_stat = (addr_i == OFS_STAT);
    hit_vec  = (addr_i == OFS_VEC);
    hit_test = (addr_i == OFS_TEST);

    ie_en   = wr_en_i & hit_ie;
    ie_d    = wdata_i[SRC_W-1:0] & IE_KEEP;
    test_en = wr_en_i & hit_test;
    test_d  = wdata_i & TEST_KEEP;

    clr  = '0;
    fill = 1'b0;
    if (IS_NEW) begin
      if (wr_en_i && hit_stat) clr = wdata_i[SRC_W-1:0];
      fill = test_en & wdata_i[TEST_FORCE_BIT];
    end else begin
      if (rd_en_i && hit_vec) clr = vec_sel;
    end
  end

  i2c_irq_status #(.W(SRC_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .set_i(evt_i),
    .clr_i(clr), .fill_i(fill), .stat_o(stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  ie_q <= '0;
    else if (ie_en)   ie_q <= ie_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  test_q <= '0;
    else if (test_en) test_q <= test_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_REV:  rdata_o = DW'(REV_CODE);
      OFS_IE:   rdata_o = DW'(ie_q);
      OFS_STAT: begin
        rdata_o = DW'(stat_q);
        rdata_o[BUSY_BIT] = bus_busy_i;
      end
      OFS_VEC:  rdata_o = IS_NEW ? '0 : DW'(vec);
      OFS_TEST: rdata_o = test_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |pend;
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter logic [7:0]  REV_CODE = 8'h34,
  parameter int unsigned SRC_W    = 6
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [SRC_W-1:0] evt_i,
  input logic [SRC_W-1:0] stat_q,
  input logic [SRC_W-1:0] ie_q,
  input logic             irq_o
);
  localparam bit IS_NEW = (REV_CODE >= REV_NEW_MIN);
  localparam logic [SRC_W-1:0] IE_KEEP = IS_NEW ? {SRC_W{1'b1}} : {1'b0, {(SRC_W-1){1'b1}}};

  AST_EVT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R10

  AST_IE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && addr_i == OFS_IE) |=> (ie_q == ($past(wdata_i[SRC_W-1:0]) & IE_KEEP))); // R6

  AST_IRQ_FALLS_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && addr_i == OFS_IE && wdata_i == '0) |=> !irq_o); // R1

  generate
    if (IS_NEW) begin : g_new
      AST_FILL_ALL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (wr_en_i && addr_i == OFS_TEST && wdata_i[TEST_FORCE_BIT]) |=> (&stat_q)); // R8
      AST_VEC_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (rd_en_i && !wr_en_i && addr_i == OFS_VEC) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4
    end else begin : g_old
      AST_STAT_RO: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (wr_en_i && !rd_en_i && addr_i == OFS_STAT && evt_i == '0) |=> $stable(stat_q)); // R5
      AST_VEC_ONE_GONE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (rd_en_i && addr_i == OFS_VEC && (stat_q & ie_q) != '0 && evt_i == '0)
        |=> ($countones(stat_q) + 1 == $countones($past(stat_q)))); // R2
    end
  endgenerate
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.REV_CODE(REV_CODE), .SRC_W(SRC_W)) u_chk (
  .clk_i(clk_i), .rst_sync_n(rst_sync_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .evt_i(evt_i), .stat_q(stat_q),
  .ie_q(ie_q), .irq_o(irq_o)
);

// File: tb/i2c_irq_unit_tb.sv
module i2c_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, busy;
  logic [5:0]  addr, evt;
  logic [15:0] wdata, rd_n_s, rd_o_s, rdata_n, rdata_o;
  logic        irq_n, irq_o, irqs_n, irqs_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_irq_unit #(.REV_CODE(8'h34)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .evt_i(evt), .bus_busy_i(busy), .rdata_o(rdata_n), .irq_o(irq_n)
  );

  i2c_irq_unit #(.REV_CODE(8'h11)) u_dut_old (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .evt_i(evt), .bus_busy_i(busy), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [31:0] req;
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic [5:0]  evt;
    logic        busy;
    logic [15:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{"R9  ", OP_RD,   6'h00, 16'h0000, 6'h00, 1'b0, 16'h0034, 1'b0},
    '{"R6  ", OP_WR,   6'h04, 16'hFFFF, 6'h00, 1'b0, 16'h0000, 1'b0},
    '{"R6  ", OP_RD,   6'h04, 16'h0000, 6'h00, 1'b0, 16'h003F, 1'b0},
    '{"R1  ", OP_IDLE, 6'h00, 16'h0000, 6'h05, 1'b0, 16'h0000, 1'b1},
    '{"R7  ", OP_RD,   6'h08, 16'h0000, 6'h00, 1'b1, 16'h1005, 1'b1},
    '{"R4  ", OP_RD,   6'h0C, 16'h0000, 6'h00, 1'b0, 16'h0000, 1'b1},
    '{"R4  ", OP_RD,   6'h08, 16'h0000, 6'h00, 1'b0, 16'h0005, 1'b1},
    '{"R4  ", OP_WR,   6'h08, 16'h0001, 6'h00, 1'b0, 16'h0000, 1'b1},
    '{"R4  ", OP_RD,   6'h08, 16'h0000, 6'h00, 1'b0, 16'h0004, 1'b1},
    '{"R10 ", OP_WR,   6'h08, 16'h0004, 6'h04, 1'b0, 16'h0000, 1'b1},
    '{"R10 ", OP_RD,   6'h08, 16'h0000, 6'h00, 1'b0, 16'h0004, 1'b1},
    '{"R4  ", OP_WR,   6'h08, 16'h00FF, 6'h00, 1'b0, 16'h0000, 1'b0},
    '{"R6  ", OP_IDLE, 6'h00, 16'h0000, 6'h20, 1'b0, 16'h0000, 1'b1},
    '{"R1  ", OP_WR,   6'h04, 16'h0001, 6'h00, 1'b0, 16'h0000, 1'b0},
    '{"R8  ", OP_WR,   6'h3C, 16'hFFFF, 6'h00, 1'b0, 16'h0000, 1'b1},
    '{"R8  ", OP_RD,   6'h3C, 16'h0000, 6'h00, 1'b0, 16'hF80F, 1'b1},
    '{"R8  ", OP_RD,   6'h08, 16'h0000, 6'h00, 1'b0, 16'h003F, 1'b1},
    '{"R9  ", OP_WR,   6'h00, 16'h1234, 6'h00, 1'b0, 16'h0000, 1'b1},
    '{"R9  ", OP_RD,   6'h00, 16'h0000, 6'h00, 1'b0, 16'h0034, 1'b1},
    '{"R4  ", OP_WR,   6'h08, 16'h003F, 6'h00, 1'b0, 16'h0000, 1'b0},
    '{"R8  ", OP_WR,   6'h3C, 16'h0001, 6'h00, 1'b0, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd,
                      input logic [5:0] ev, input logic bz);
    @(negedge clk);
    wr_en = (op == OP_WR);
    rd_en = (op == OP_RD);
    addr  = a;
    wdata = wd;
    evt   = ev;
    busy  = bz;
    #1;
    rd_n_s = rdata_n;
    rd_o_s = rdata_o;
    @(posedge clk);
    #1;
    irqs_n = irq_n;
    irqs_o = irq_o;
    wr_en = 1'b0;
    rd_en = 1'b0;
    evt   = '0;
    busy  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; evt = '0; busy = 0;
    do_reset();

    // R11: reset state of both generations
    chk("R11 irq new", 16'(irq_n), 16'h0);
    chk("R11 irq old", 16'(irq_o), 16'h0);
    step(OP_RD, 6'h08, 0, 0, 0); chk("R11 stat new", rd_n_s, 16'h0); chk("R11 stat old", rd_o_s, 16'h0);
    step(OP_RD, 6'h04, 0, 0, 0); chk("R11 ie new", rd_n_s, 16'h0);   chk("R11 ie old", rd_o_s, 16'h0);
    step(OP_RD, 6'h3C, 0, 0, 0); chk("R11 test new", rd_n_s, 16'h0); chk("R11 test old", rd_o_s, 16'h0);

    // Table walk on the newer generation
    for (int k = 0; k < NV; k++) begin
      step(TBL[k].op, TBL[k].addr, TBL[k].wd, TBL[k].evt, TBL[k].busy);
      if (TBL[k].op == OP_RD) chk($sformatf("%s vec %0d rdata", TBL[k].req, k), rd_n_s, TBL[k].exp_rd);
      chk($sformatf("%s vec %0d irq", TBL[k].req, k), 16'(irqs_n), 16'(TBL[k].exp_irq));
    end

    // Directed tests on the older generation
    do_reset();
    step(OP_WR, 6'h04, 16'hFFFF, 0, 0);
    step(OP_RD, 6'h04, 0, 0, 0);        chk("R6 old ie", rd_o_s, 16'h001F);
    step(OP_IDLE, 0, 0, 6'h2A, 0);      chk("R1 old irq set", 16'(irqs_o), 16'h1);
    step(OP_RD, 6'h0C, 0, 0, 0);        chk("R2 old vec lowest", rd_o_s, 16'h0002);
                                        chk("R1 old irq still", 16'(irqs_o), 16'h1);
    step(OP_RD, 6'h08, 0, 0, 0);        chk("R2 old stat one cleared", rd_o_s, 16'h0028);
    step(OP_WR, 6'h08, 16'h003F, 0, 0);
    step(OP_RD, 6'h08, 0, 0, 0);        chk("R5 old stat write ignored", rd_o_s, 16'h0028);
    step(OP_RD, 6'h0C, 0, 0, 0);        chk("R2 old vec next", rd_o_s, 16'h0004);
                                        chk("R1 old irq drops", 16'(irqs_o), 16'h0);
    step(OP_RD, 6'h0C, 0, 0, 0);        chk("R3 old vec empty", rd_o_s, 16'h0000);
    step(OP_RD, 6'h08, 0, 0, 1);        chk("R3 R7 old stat kept", rd_o_s, 16'h1020);
    step(OP_WR, 6'h3C, 16'hFFFF, 0, 0); chk("R8 old no fill irq", 16'(irqs_o), 16'h0);
    step(OP_RD, 6'h08, 0, 0, 0);        chk("R8 old no fill stat", rd_o_s, 16'h0020);
    step(OP_RD, 6'h3C, 0, 0, 0);        chk("R8 old test mask", rd_o_s, 16'hF80F);
    step(OP_RD, 6'h00, 0, 0, 0);        chk("R9 old rev", rd_o_s, 16'h0011);
    step(OP_IDLE, 0, 0, 6'h01, 0);      chk("R1 old irq bit0", 16'(irqs_o), 16'h1);
    step(OP_RD, 6'h0C, 0, 6'h01, 0);    chk("R10 old vec collide", rd_o_s, 16'h0001);
                                        chk("R10 old irq kept", 16'(irqs_o), 16'h1);
    step(OP_RD, 6'h08, 0, 0, 0);        chk("R10 old stat kept", rd_o_s, 16'h0021);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule